// File: doc/BRIEF.md
# Three-Level Flying-Capacitor Full-Wave Leg Modulator

This block drives the four gates of one leg of a three-level flying-capacitor inverter with a full-wave (one pulse per half period) waveform. A phase counter runs through one fundamental period, counted in clock cycles. The counter is folded into two halves. In each half the output sits at the zero level for a programmable number of clocks at both ends of the half. In the middle of the first half it is at the positive level and in the middle of the second half it is at the negative level. This is the same waveform that two centred carrier-versus-threshold comparisons give. Here it is derived from a single counter.

The zero level can be built from either of two redundant switch combinations: A (outer switch T1 on, inner switch T2 off) or B (T2 on, T1 off). A mode input picks how the block chooses between them:
- **Fixed mode** always uses A.
- **Rotate mode** uses A and B in alternate fundamental periods, so that switch losses even out over two periods.
- **Chop mode** alternates A and B every few clocks inside each zero run, so that both states get equal time within one period.

The configuration inputs (mode, period, zero length and chop length) are captured only at a period boundary, or continuously while the block is disabled. A 2-bit level code derived from the gate states is provided for observation.

Top module: `fcz_leg_mod`

## Requirements
- R1: While reset is high or enable is low, the gate outputs register all four gates low and the level code as 2'b00 on the next clock edge.
- R2: While enabled, the outputs are complementary pairs: t3_o equals the inverse of t1_o and t4_o equals the inverse of t2_o.
- R3: Let P be the period in clocks and H = P/2. The k-th enabled clock edge after enable rises (counting from 0) shows phase n = k mod P. Define the offset within the half as f = n for n < H and f = n - H otherwise. The output is at the zero level when f < Z or f >= H - Z, where Z is the zero length. Otherwise it is at the positive level (t1_o and t2_o both high) for n < H and at the negative level (both low) for n >= H.
- R4: The level code is 2'b01 for the positive level, 2'b00 for the zero level and 2'b11 for the negative level.
- R5: In fixed mode (mode code 2'b00, with 2'b11 treated the same way), every zero-level clock uses combination A: t1_o high, t2_o low.
- R6: In rotate mode (mode code 2'b01), zero-level clocks use combination A during even periods and combination B (t1_o low, t2_o high) during odd periods. Periods are counted from 0 at the enable edge.
- R7: In chop mode (mode code 2'b10), a contiguous run of zero-level clocks starts with combination A and switches combination every C clocks, where C is the chop length. A run that crosses a half or period boundary continues its count, and each new run restarts with A.
- R8: Mode, period, zero length and chop length are captured from the inputs only on the clock that ends a period, and on every clock while the block is disabled. A change in the middle of a period has no effect until the next period.
- R9: Dropping enable returns the phase to 0 and the period parity to even, so that the first period after re-enable behaves as period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| mode_i | input | 2 | Zero-state policy: 00 fixed, 01 rotate, 10 chop, 11 fixed |
| period_i | input | PER_W | Fundamental period in clocks (even, at least 4) |
| zlen_i | input | PER_W | Zero-level clocks at each end of a half period |
| chop_i | input | CHOP_W | Clocks spent in each combination in chop mode (at least 1) |
| t1_o | output | 1 | Outer switch of cell 1 |
| t2_o | output | 1 | Inner switch of cell 2 |
| t3_o | output | 1 | Complement of T1 |
| t4_o | output | 1 | Complement of T2 |
| lvl_o | output | 2 | Level code: 01 positive, 00 zero, 11 negative |

## Verification
A parity flip-flop in the wrong state makes the first zero clock of a rotate-mode period, at phase 0, use the wrong combination. That clock is the first one after the boundary, so the error shows at once. A chop counter that is off by one moves the first A-to-B swap of a zero run by a clock, and this shows within C+1 clocks of the start of the run. A phase counter or latched period that is out of step shifts every level edge and every expected gate state from that clock on. For this reason the bench compares every output on every clock against a model built from the requirements.

// File: rtl/fcz_pkg.sv
package fcz_pkg;

  typedef enum logic [1:0] {
    ZM_FIXED     = 2'b00,
    ZM_ROTATE    = 2'b01,
    ZM_CHOP      = 2'b10,
    ZM_FIXED_ALT = 2'b11
  } zmode_e;

  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_NEG  = 2'b11;

  // Level code from outer/inner gate states.
  function automatic logic [1:0] lvl_of(input logic outer, input logic inner);
    if (outer && inner)        return LV_POS;
    else if (!outer && !inner) return LV_NEG;
    else                       return LV_ZERO;
  endfunction

endpackage

// File: rtl/fcz_phase_gen.sv
module fcz_phase_gen
  import fcz_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int CHOP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PER_W-1:0]  period_i,
  input  logic [PER_W-1:0]  zlen_i,
  input  logic [CHOP_W-1:0] chop_i,
  input  zmode_e            mode_i,
  output logic [PER_W-1:0]  ph_q,
  output logic              par_q,
  output logic [PER_W-1:0]  period_q,
  output logic [PER_W-1:0]  zlen_q,
  output logic [CHOP_W-1:0] chop_q,
  output zmode_e            mode_q
);

  logic wrap;
  assign wrap = (ph_q == period_q - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph_q     <= '0;
      par_q    <= 1'b0;
      period_q <= period_i;
      zlen_q   <= zlen_i;
      chop_q   <= chop_i;
      mode_q   <= mode_i;
    end else if (wrap) begin
      ph_q     <= '0;
      par_q    <= ~par_q;
      period_q <= period_i;
      zlen_q   <= zlen_i;
      chop_q   <= chop_i;
      mode_q   <= mode_i;
    end else begin
      ph_q <= ph_q + PER_W'(1);
    end
  end

endmodule

// File: rtl/fcz_level_dec.sv
module fcz_level_dec #(
  parameter int PER_W = 16
) (
  input  logic [PER_W-1:0] ph,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] zlen,
  output logic             is_zero,
  output logic             is_pos
);

  logic [PER_W-1:0] half;
  logic [PER_W-1:0] off;

  always_comb begin
    half    = period >> 1;
    is_pos  = (ph < half);
    off     = is_pos ? ph : (ph - half);
    if (zlen >= half) is_zero = 1'b1;
    else              is_zero = (off < zlen) || (off >= half - zlen);
  end

endmodule

// File: rtl/fcz_chop_timer.sv
module fcz_chop_timer #(
  parameter int CHOP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              is_zero,
  input  logic [CHOP_W-1:0] chop_len,
  output logic              flag_q
);

  logic [CHOP_W-1:0] cnt_q;

  // Count restarts at every new zero run, so each run begins on combination A.
  always_ff @(posedge clk) begin
    if (rst || !en || !is_zero) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_q == chop_len - CHOP_W'(1)) begin
      cnt_q  <= '0;
      flag_q <= ~flag_q;
    end else begin
      cnt_q <= cnt_q + CHOP_W'(1);
    end
  end

endmodule

// File: rtl/fcz_gate_out.sv
module fcz_gate_out
  import fcz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       is_zero,
  input  logic       is_pos,
  input  zmode_e     mode,
  input  logic       par,
  input  logic       chop_flag,
  output logic       t1_o,
  output logic       t2_o,
  output logic       t3_o,
  output logic       t4_o,
  output logic [1:0] lvl_o
);

  logic sel_b;
  logic nx_outer;
  logic nx_inner;

  always_comb begin
    unique case (mode)
      ZM_ROTATE: sel_b = par;
      ZM_CHOP:   sel_b = chop_flag;
      default:   sel_b = 1'b0;
    endcase
    if (is_zero) begin
      nx_outer = ~sel_b;
      nx_inner = sel_b;
    end else begin
      nx_outer = is_pos;
      nx_inner = is_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      t1_o  <= 1'b0;
      t2_o  <= 1'b0;
      t3_o  <= 1'b0;
      t4_o  <= 1'b0;
      lvl_o <= LV_ZERO;
    end else begin
      t1_o  <= nx_outer;
      t3_o  <= ~nx_outer;
      t2_o  <= nx_inner;
      t4_o  <= ~nx_inner;
      lvl_o <= lvl_of(nx_outer, nx_inner);
    end
  end

endmodule

// File: rtl/fcz_leg_mod.sv
module fcz_leg_mod
  import fcz_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int CHOP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [PER_W-1:0]  zlen_i,
  input  logic [CHOP_W-1:0] chop_i,
  output logic              t1_o,
  output logic              t2_o,
  output logic              t3_o,
  output logic              t4_o,
  output logic [1:0]        lvl_o
);

  logic [PER_W-1:0]  ph_q;
  logic              par_q;
  logic [PER_W-1:0]  period_q;
  logic [PER_W-1:0]  zlen_q;
  logic [CHOP_W-1:0] chop_q;
  zmode_e            mode_q;
  logic              is_zero;
  logic              is_pos;
  logic              chop_flag;

  fcz_phase_gen #(.PER_W(PER_W), .CHOP_W(CHOP_W)) u_phase (
    .clk(clk), .rst(rst), .en(en),
    .period_i(period_i), .zlen_i(zlen_i), .chop_i(chop_i),
    .mode_i(zmode_e'(mode_i)),
    .ph_q(ph_q), .par_q(par_q), .period_q(period_q),
    .zlen_q(zlen_q), .chop_q(chop_q), .mode_q(mode_q)
  );

  fcz_level_dec #(.PER_W(PER_W)) u_level (
    .ph(ph_q), .period(period_q), .zlen(zlen_q),
    .is_zero(is_zero), .is_pos(is_pos)
  );

  fcz_chop_timer #(.CHOP_W(CHOP_W)) u_chop (
    .clk(clk), .rst(rst), .en(en), .is_zero(is_zero),
    .chop_len(chop_q), .flag_q(chop_flag)
  );

  fcz_gate_out u_gate (
    .clk(clk), .rst(rst), .en(en),
    .is_zero(is_zero), .is_pos(is_pos), .mode(mode_q),
    .par(par_q), .chop_flag(chop_flag),
    .t1_o(t1_o), .t2_o(t2_o), .t3_o(t3_o), .t4_o(t4_o), .lvl_o(lvl_o)
  );

endmodule

// File: rtl/fcz_leg_mod_chk.sv
module fcz_leg_mod_chk
  import fcz_pkg::*;
#(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             t1_o,
  input logic             t2_o,
  input logic             t3_o,
  input logic             t4_o,
  input logic [1:0]       lvl_o,
  input zmode_e           mode_q,
  input logic [PER_W-1:0] ph_q
);

  AST_IDLE_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) || $past(rst)) |-> (!t1_o && !t2_o && !t3_o && !t4_o && lvl_o == 2'b00)); // R1

  AST_CELL_COMPL: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> ((t3_o == !t1_o) && (t4_o == !t2_o))); // R2

  AST_LVL_POS: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && t1_o && t2_o) |-> (lvl_o == LV_POS)); // R4

  AST_LVL_NEG: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && !t1_o && !t2_o) |-> (lvl_o == LV_NEG)); // R4

  AST_LVL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && (t1_o != t2_o)) |-> (lvl_o == LV_ZERO)); // R4

  AST_FIXED_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && ($past(mode_q) == ZM_FIXED || $past(mode_q) == ZM_FIXED_ALT)
     && lvl_o == LV_ZERO) |-> (t1_o && !t2_o)); // R5

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && ph_q != '0) |-> $stable(mode_q)); // R8

endmodule

bind fcz_leg_mod fcz_leg_mod_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .t1_o(t1_o), .t2_o(t2_o), .t3_o(t3_o), .t4_o(t4_o), .lvl_o(lvl_o),
  .mode_q(mode_q), .ph_q(ph_q)
);

// File: tb/fcz_leg_mod_tb.sv
module fcz_leg_mod_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PER_W  = 16;
  localparam int CHOP_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en  = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic [PER_W-1:0]  period_i = '0;
  logic [PER_W-1:0]  zlen_i = '0;
  logic [CHOP_W-1:0] chop_i = '0;
  logic t1_o, t2_o, t3_o, t4_o;
  logic [1:0] lvl_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcz_leg_mod #(.PER_W(PER_W), .CHOP_W(CHOP_W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mode_i(mode_i),
    .period_i(period_i), .zlen_i(zlen_i), .chop_i(chop_i),
    .t1_o(t1_o), .t2_o(t2_o), .t3_o(t3_o), .t4_o(t4_o), .lvl_o(lvl_o)
  );

  typedef struct {
    logic       act;
    logic       a;
    logic       b;
    logic [1:0] lvl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state, kept from the requirement text.
  int mph = 0, mpar = 0, mmode = 0, mP = 0, mZ = 0, mC = 1, mcnt = 0, mflag = 0;

  task automatic cyc(input logic r, input logic e, input int m, input int p,
                     input int z, input int c, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; en = e; mode_i = 2'(m);
    period_i = PER_W'(p); zlen_i = PER_W'(z); chop_i = CHOP_W'(c);
    x.tag = tag;
    if (r || !e) begin
      x.act = 0; x.a = 0; x.b = 0; x.lvl = 2'b00;
      mph = 0; mpar = 0; mcnt = 0; mflag = 0;
      mmode = m; mP = p; mZ = z; mC = c;
    end else begin
      int h, f, selb;
      bit zr;
      h = mP / 2;
      f = (mph < h) ? mph : mph - h;
      zr = (f < mZ) || (f >= h - mZ);
      x.act = 1;
      if (zr) begin
        selb = (mmode == 1) ? mpar : (mmode == 2) ? mflag : 0;
        x.a = (selb == 0); x.b = (selb != 0); x.lvl = 2'b00;
      end else if (mph < h) begin
        x.a = 1; x.b = 1; x.lvl = 2'b01;
      end else begin
        x.a = 0; x.b = 0; x.lvl = 2'b11;
      end
      if (zr) begin
        if (mcnt == mC - 1) begin mcnt = 0; mflag ^= 1; end
        else mcnt++;
      end else begin
        mcnt = 0; mflag = 0;
      end
      if (mph == mP - 1) begin
        mph = 0; mpar ^= 1; mmode = m; mP = p; mZ = z; mC = c;
      end else mph++;
    end
    q.push_back(x);
  endtask

  // Monitor: compare one expected item per clock edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (t1_o !== x.a || t2_o !== x.b) begin
        errors++;
        $display("FAIL %s gates t1/t2 act=%b%b exp=%b%b t=%0t", x.tag, t1_o, t2_o, x.a, x.b, $time);
      end
      checks++;
      if (x.act) begin
        if (t3_o !== !t1_o || t4_o !== !t2_o) begin
          errors++;
          $display("FAIL R2 complement t3/t4 act=%b%b exp=%b%b t=%0t", t3_o, t4_o, !t1_o, !t2_o, $time);
        end
      end else if (t3_o !== 1'b0 || t4_o !== 1'b0) begin
        errors++;
        $display("FAIL R1 idle t3/t4 act=%b%b exp=00 t=%0t", t3_o, t4_o, $time);
      end
      checks++;
      if (lvl_o !== x.lvl) begin
        errors++;
        $display("FAIL %s level code act=%b exp=%b t=%0t", x.act ? "R4" : "R1", lvl_o, x.lvl, $time);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset, then idle while disabled
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 40, 6, 2, "R1");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 40, 6, 2, "R1");
    // R3 and R5: fixed mode, two periods
    for (int i = 0; i < 80; i++) cyc(0, 1, 0, 40, 6, 2, "R3");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 40, 6, 2, "R5");
    // R8: mid-period change to rotate with a new period; must wait for boundary
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, 24, 4, 2, "R8");
    // R6: rotate over several periods
    for (int i = 0; i < 96; i++) cyc(0, 1, 1, 24, 4, 2, "R6");
    // R7: chop with C=2, then C=3 (change lands at boundary)
    for (int i = 0; i < 72; i++) cyc(0, 1, 2, 24, 4, 2, "R7");
    for (int i = 0; i < 72; i++) cyc(0, 1, 2, 32, 7, 3, "R7");
    // R1 and R9: drop enable mid-period, then re-enable in rotate mode
    for (int i = 0; i < 13; i++) cyc(0, 1, 1, 32, 7, 3, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 20, 3, 1, "R1");
    for (int i = 0; i < 60; i++) cyc(0, 1, 1, 20, 3, 1, "R9");
    // R5: fixed alternate code 2'b11 behaves as fixed
    for (int i = 0; i < 40; i++) cyc(0, 1, 3, 20, 3, 1, "R5");
    // R3: zero length 0, pure two-level square wave
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 20, 0, 1, "R3");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule